// File: doc/BRIEF.md
# Slow-Clock Match Counter

This block is a free-running up-counter of configurable width (32 bits by default). It advances once for each rising edge of a slow external reference, typically a 32.768 kHz crystal clock. The reference is not used as a clock. It is resynchronised into the system clock domain and edge-detected, so the whole block runs on one system clock.

Software programs a compare value and, if needed, a new starting count. It then sets the run bit. Each time the counter steps onto the compare value, a sticky status flag is set. A per-source mask decides whether that flag drives the interrupt line. The counter never stops or reloads on a match. After a new starting count is written, it counts up to all-ones and wraps to zero.

An external hold input can freeze counting, provided software has armed it. Configuration registers can only be changed while the counter is not running.

Top module: `lsc_match_timer`

## Requirements
- R1: After reset the count, compare value, start value, control bits, status flag, mask and `irq_o` are all zero.
- R2: While the run bit (bit 0 of the control register, address 0) is 1, each rising edge of `slow_clk_i` adds one to the count. The new count is readable three system clocks after the edge is applied. The counter advances at most once per two system clocks. While the run bit is 0, the count holds.
- R3: Writing the start-value register (address 2) while stopped sets the count to the written value on the next clock. Counting then continues up to all-ones and wraps to zero.
- R4: When the counter advances onto the compare value (address 1), the status flag (bit 0 of address 4) is set in the same clock that the count shows that value. Counting continues afterwards. Loading the compare value directly does not count as a match.
- R5: Writing 1 to bit 0 of the clear register (address 6) clears the status flag on the next clock. Writing 0 there has no effect.
- R6: If a clear write and a new match fall in the same clock, the flag ends up set.
- R7: `irq_o` and bit 0 of address 7 equal the status flag ANDed with the mask bit (bit 0 of address 5).
- R8: While the run bit is 1, writes to the compare, start-value and mask registers, and to the hold-enable bit (bit 1 of address 0), are ignored. The run bit itself is always writable.
- R9: When the hold-enable bit is set, a high `stall_i` freezes the count and slow edges seen meanwhile are dropped. When hold-enable is clear, `stall_i` has no effect.
- R10: Reads return control at address 0, compare at 1, start value at 2, live count at 3, raw flag at 4, mask at 5, zero at 6 and masked flag at 7, all zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| slow_clk_i | input | 1 | Asynchronous slow reference whose rising edges are counted |
| stall_i | input | 1 | Hold request, honoured when hold-enable is set |
| reg_wr_i | input | 1 | Register write strobe, one clock per write |
| reg_addr_i | input | 3 | Register address for reads and writes |
| reg_wdata_i | input | CNT_W | Register write data |
| reg_rdata_o | output | CNT_W | Register read data, combinational from the address |
| irq_o | output | 1 | Masked match interrupt |

## Verification
Register writes take effect on the clock edge inside the write strobe. The bench samples on the falling edge after that strobe, so control, compare, mask and clear results are checked one clock after the write. A slow-clock rising edge passes through two synchroniser stages and an edge register before reaching the counter. The bench therefore checks that the count has not changed two clocks after the edge and has changed after the third. The flag set and the count step share that third edge. The simultaneous clear-and-match case is built by placing the clear strobe on exactly that edge. Every other slow pulse is held for three clocks high and three low, and the bench reads the count only after the pulse has ended.

// File: rtl/lsc_pkg.sv
package lsc_pkg;

  localparam int unsigned REG_AW = 3;

  typedef enum logic [REG_AW-1:0] {
    A_CTRL  = 3'd0,
    A_MATCH = 3'd1,
    A_LOAD  = 3'd2,
    A_COUNT = 3'd3,
    A_RAW   = 3'd4,
    A_MASK  = 3'd5,
    A_CLEAR = 3'd6,
    A_MIS   = 3'd7
  } reg_addr_e;

  localparam int unsigned CTRL_RUN_BIT   = 0;
  localparam int unsigned CTRL_STALL_BIT = 1;
  localparam int unsigned FLAG_BIT       = 0;

endpackage

// File: rtl/lsc_edge_sync.sv
module lsc_edge_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic async_i,
  output logic tick_o
);

  localparam int unsigned MSB = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic                   prev_q, prev_d;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_comb sync_d = async_i;
    end else begin : g_chain
      always_comb sync_d = {sync_q[SYNC_STAGES-2:0], async_i};
    end
  endgenerate

  always_comb prev_d = sync_q[MSB];

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  assign tick_o = sync_q[MSB] & ~prev_q;

  AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_ni)
    tick_o |=> !tick_o); // R2

endmodule

// File: rtl/lsc_counter.sv
module lsc_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             stall_en_i,
  input  logic             stall_i,
  input  logic             tick_i,
  input  logic             load_we_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic [CNT_W-1:0] match_val_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             hit_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc;
  logic             cnt_en, frozen, advance;

  always_comb begin
    frozen  = stall_en_i & stall_i;
    advance = run_i & tick_i & ~frozen & ~load_we_i;
    cnt_inc = cnt_q + {{(CNT_W-1){1'b0}}, 1'b1};
    cnt_en  = load_we_i | advance;
    cnt_d   = load_we_i ? load_val_i : cnt_inc;
    hit_o   = advance & (cnt_inc == match_val_i);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_ni)
    (!run_i && !load_we_i) |=> $stable(cnt_q)); // R2

  AST_STALL_FREEZE: assert property (@(posedge clk) disable iff (!rst_ni)
    (stall_en_i && stall_i && !load_we_i) |=> $stable(cnt_q)); // R9

  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_ni)
    load_we_i |=> (cnt_q == $past(load_val_i))); // R3

endmodule

// File: rtl/lsc_status.sv
module lsc_status (
  input  logic clk,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  input  logic mask_i,
  output logic flag_o,
  output logic irq_o
);

  logic flag_q, flag_d;

  always_comb flag_d = set_i | (flag_q & ~clr_i);

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) flag_q <= 1'b0;
    else         flag_q <= flag_d;
  end

  assign flag_o = flag_q;
  assign irq_o  = flag_q & mask_i;

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_ni)
    set_i |=> flag_q); // R6

  AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !flag_q); // R5

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_ni)
    (flag_q && !clr_i) |=> flag_q); // R4

endmodule

// File: rtl/lsc_regs.sv
module lsc_regs
  import lsc_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] cnt_i,
  input  logic              flag_i,
  input  logic              irq_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              run_o,
  output logic              stall_en_o,
  output logic [DATA_W-1:0] match_o,
  output logic              load_we_o,
  output logic [DATA_W-1:0] load_val_o,
  output logic              mask_o,
  output logic              clr_o
);

  localparam int unsigned PAD_CTRL = DATA_W - 2;
  localparam int unsigned PAD_BIT  = DATA_W - 1;

  logic              run_q, run_d;
  logic              stall_en_q, stall_en_d;
  logic [DATA_W-1:0] match_q, match_d;
  logic [DATA_W-1:0] load_q, load_d;
  logic              mask_q, mask_d;
  logic              cfg_ok;
  logic              sel_ctrl, sel_match, sel_load, sel_mask, sel_clear;

  always_comb begin
    cfg_ok    = wr_i & ~run_q;
    sel_ctrl  = (addr_i == A_CTRL);
    sel_match = (addr_i == A_MATCH);
    sel_load  = (addr_i == A_LOAD);
    sel_mask  = (addr_i == A_MASK);
    sel_clear = (addr_i == A_CLEAR);

    run_d      = (wr_i & sel_ctrl)    ? wdata_i[CTRL_RUN_BIT]   : run_q;
    stall_en_d = (cfg_ok & sel_ctrl)  ? wdata_i[CTRL_STALL_BIT] : stall_en_q;
    match_d    = (cfg_ok & sel_match) ? wdata_i                 : match_q;
    load_d     = (cfg_ok & sel_load)  ? wdata_i                 : load_q;
    mask_d     = (cfg_ok & sel_mask)  ? wdata_i[FLAG_BIT]       : mask_q;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q      <= 1'b0;
      stall_en_q <= 1'b0;
      match_q    <= '0;
      load_q     <= '0;
      mask_q     <= 1'b0;
    end else begin
      run_q      <= run_d;
      stall_en_q <= stall_en_d;
      match_q    <= match_d;
      load_q     <= load_d;
      mask_q     <= mask_d;
    end
  end

  always_comb begin
    case (reg_addr_e'(addr_i))
      A_CTRL:  rdata_o = {{PAD_CTRL{1'b0}}, stall_en_q, run_q};
      A_MATCH: rdata_o = match_q;
      A_LOAD:  rdata_o = load_q;
      A_COUNT: rdata_o = cnt_i;
      A_RAW:   rdata_o = {{PAD_BIT{1'b0}}, flag_i};
      A_MASK:  rdata_o = {{PAD_BIT{1'b0}}, mask_q};
      A_MIS:   rdata_o = {{PAD_BIT{1'b0}}, irq_i};
      default: rdata_o = '0;
    endcase
  end

  assign run_o      = run_q;
  assign stall_en_o = stall_en_q;
  assign match_o    = match_q;
  assign load_we_o  = cfg_ok & sel_load;
  assign load_val_o = wdata_i;
  assign mask_o     = mask_q;
  assign clr_o      = wr_i & sel_clear & wdata_i[FLAG_BIT];

  AST_CFG_LOCK_MATCH: assert property (@(posedge clk) disable iff (!rst_ni)
    (run_q && wr_i && sel_match) |=> $stable(match_q)); // R8

  AST_CFG_LOCK_MASK: assert property (@(posedge clk) disable iff (!rst_ni)
    (run_q && wr_i && sel_mask) |=> $stable(mask_q)); // R8

  AST_CFG_LOCK_LOAD: assert property (@(posedge clk) disable iff (!rst_ni)
    run_q |-> !load_we_o); // R8

endmodule

// File: rtl/lsc_match_timer.sv
module lsc_match_timer
  import lsc_pkg::*;
#(
  parameter int unsigned CNT_W       = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slow_clk_i,
  input  logic              stall_i,
  input  logic              reg_wr_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [CNT_W-1:0]  reg_wdata_i,
  output logic [CNT_W-1:0]  reg_rdata_o,
  output logic              irq_o
);

  logic [1:0]       rst_pipe_q;
  logic             rst_ni;
  logic             tick;
  logic             run, stall_en, load_we, mask, clr, hit, flag, irq;
  logic [CNT_W-1:0] match_val, load_val, cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end

  assign rst_ni = rst_pipe_q[1];

  lsc_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_ni  (rst_ni),
    .async_i (slow_clk_i),
    .tick_o  (tick)
  );

  lsc_regs #(.DATA_W(CNT_W)) u_regs (
    .clk        (clk),
    .rst_ni     (rst_ni),
    .wr_i       (reg_wr_i),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .cnt_i      (cnt),
    .flag_i     (flag),
    .irq_i      (irq),
    .rdata_o    (reg_rdata_o),
    .run_o      (run),
    .stall_en_o (stall_en),
    .match_o    (match_val),
    .load_we_o  (load_we),
    .load_val_o (load_val),
    .mask_o     (mask),
    .clr_o      (clr)
  );

  lsc_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk         (clk),
    .rst_ni      (rst_ni),
    .run_i       (run),
    .stall_en_i  (stall_en),
    .stall_i     (stall_i),
    .tick_i      (tick),
    .load_we_i   (load_we),
    .load_val_i  (load_val),
    .match_val_i (match_val),
    .cnt_o       (cnt),
    .hit_o       (hit)
  );

  lsc_status u_stat (
    .clk    (clk),
    .rst_ni (rst_ni),
    .set_i  (hit),
    .clr_i  (clr),
    .mask_i (mask),
    .flag_o (flag),
    .irq_o  (irq)
  );

  assign irq_o = irq;

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_ni)
    irq_o |-> (flag && mask)); // R7

  AST_HIT_SHOWS: assert property (@(posedge clk) disable iff (!rst_ni)
    hit |=> (flag && cnt == match_val)); // R4

endmodule

// File: tb/lsc_match_timer_bench.sv
module lsc_match_timer_bench;
  import lsc_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        slow_clk = 1'b0;
  logic        stall = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  lsc_match_timer u_lsc_match_timer (
    .clk         (clk),
    .rst_n       (rst_n),
    .slow_clk_i  (slow_clk),
    .stall_i     (stall),
    .reg_wr_i    (reg_wr),
    .reg_addr_i  (reg_addr),
    .reg_wdata_i (reg_wdata),
    .reg_rdata_o (reg_rdata),
    .irq_o       (irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic pulse();
    @(negedge clk); slow_clk = 1'b1;
    repeat (3) @(negedge clk);
    slow_clk = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(A_CTRL, v);  chk("R1 ctrl", v, 32'd0);
    rd(A_COUNT, v); chk("R1 count", v, 32'd0);
    rd(A_MATCH, v); chk("R1 match", v, 32'd0);
    rd(A_RAW, v);   chk("R1 flag", v, 32'd0);
    chk("R1 irq", {31'd0, irq}, 32'd0);
  endtask

  task automatic t_count();
    logic [31:0] v;
    wr(A_CTRL, 32'd1);
    @(negedge clk); slow_clk = 1'b1;
    repeat (2) @(negedge clk);
    rd(A_COUNT, v); chk("R2 latency two clocks", v, 32'd0);
    @(negedge clk);
    rd(A_COUNT, v); chk("R2 latency three clocks", v, 32'd1);
    slow_clk = 1'b0;
    repeat (3) @(negedge clk);
    for (int i = 0; i < 4; i++) pulse();
    rd(A_COUNT, v); chk("R2 five edges", v, 32'd5);
  endtask

  task automatic t_idle();
    logic [31:0] v;
    wr(A_CTRL, 32'd0);
    pulse(); pulse();
    rd(A_COUNT, v); chk("R2 stopped holds", v, 32'd5);
  endtask

  task automatic t_load();
    logic [31:0] v;
    wr(A_LOAD, 32'hFFFF_FFFE);
    rd(A_COUNT, v); chk("R3 load count", v, 32'hFFFF_FFFE);
    rd(A_LOAD, v);  chk("R3 load readback", v, 32'hFFFF_FFFE);
    wr(A_CTRL, 32'd1);
    pulse();
    rd(A_COUNT, v); chk("R3 all ones", v, 32'hFFFF_FFFF);
    pulse();
    rd(A_COUNT, v); chk("R3 wrap", v, 32'd0);
    rd(A_RAW, v);   chk("R4 match at zero", v, 32'd1);
  endtask

  task automatic t_lock();
    logic [31:0] v;
    wr(A_MATCH, 32'h1234);
    rd(A_MATCH, v); chk("R8 match locked", v, 32'd0);
    wr(A_LOAD, 32'h55);
    rd(A_COUNT, v); chk("R8 load ignored count", v, 32'd0);
    rd(A_LOAD, v);  chk("R8 load locked", v, 32'hFFFF_FFFE);
    wr(A_CTRL, 32'd3);
    rd(A_CTRL, v);  chk("R8 hold enable locked", v, 32'd1);
    wr(A_MASK, 32'd1);
    rd(A_MASK, v);  chk("R8 mask locked", v, 32'd0);
  endtask

  task automatic t_clear();
    logic [31:0] v;
    wr(A_CLEAR, 32'd0);
    rd(A_RAW, v); chk("R5 zero write keeps", v, 32'd1);
    wr(A_CLEAR, 32'd1);
    rd(A_RAW, v); chk("R5 clear", v, 32'd0);
  endtask

  task automatic t_match();
    logic [31:0] v;
    wr(A_CTRL, 32'd0);
    wr(A_MATCH, 32'h10);
    wr(A_LOAD, 32'h0E);
    rd(A_RAW, v); chk("R4 load onto no match", v, 32'd0);
    wr(A_CTRL, 32'd1);
    pulse();
    rd(A_COUNT, v); chk("R4 before match", v, 32'h0F);
    rd(A_RAW, v);   chk("R4 no flag early", v, 32'd0);
    pulse();
    rd(A_COUNT, v); chk("R4 at match", v, 32'h10);
    rd(A_RAW, v);   chk("R4 flag set", v, 32'd1);
    chk("R7 masked irq low", {31'd0, irq}, 32'd0);
    pulse();
    rd(A_COUNT, v); chk("R4 keeps counting", v, 32'h11);
    rd(A_RAW, v);   chk("R4 flag sticky", v, 32'd1);
  endtask

  task automatic t_mask();
    logic [31:0] v;
    wr(A_CTRL, 32'd0);
    wr(A_MASK, 32'd1);
    chk("R7 irq with mask", {31'd0, irq}, 32'd1);
    rd(A_MIS, v); chk("R7 masked status", v, 32'd1);
    wr(A_CLEAR, 32'd1);
    chk("R7 irq after clear", {31'd0, irq}, 32'd0);
    rd(A_MIS, v); chk("R7 masked status cleared", v, 32'd0);
  endtask

  task automatic t_same();
    logic [31:0] v;
    wr(A_LOAD, 32'h0F);
    wr(A_CTRL, 32'd1);
    @(negedge clk); slow_clk = 1'b1;
    repeat (2) @(negedge clk);
    reg_wr = 1'b1; reg_addr = A_CLEAR; reg_wdata = 32'd1;
    @(negedge clk);
    reg_wr = 1'b0;
    slow_clk = 1'b0;
    repeat (3) @(negedge clk);
    rd(A_COUNT, v); chk("R6 count at match", v, 32'h10);
    rd(A_RAW, v);   chk("R6 set beats clear", v, 32'd1);
    wr(A_CLEAR, 32'd1);
  endtask

  task automatic t_stall();
    logic [31:0] v;
    wr(A_CTRL, 32'd0);
    wr(A_CTRL, 32'd3);
    rd(A_CTRL, v); chk("R9 hold armed", v, 32'd3);
    stall = 1'b1;
    pulse(); pulse();
    rd(A_COUNT, v); chk("R9 frozen", v, 32'h10);
    stall = 1'b0;
    pulse();
    rd(A_COUNT, v); chk("R9 resumes", v, 32'h11);
    wr(A_CTRL, 32'd0);
    wr(A_CTRL, 32'd1);
    stall = 1'b1;
    pulse();
    rd(A_COUNT, v); chk("R9 unarmed ignored", v, 32'h12);
    stall = 1'b0;
  endtask

  task automatic t_readmap();
    logic [31:0] v;
    rd(A_CLEAR, v); chk("R10 clear reads zero", v, 32'd0);
    rd(A_CTRL, v);  chk("R10 ctrl read", v, 32'd1);
    rd(A_MASK, v);  chk("R10 mask read", v, 32'd1);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_count();
    t_idle();
    t_load();
    t_lock();
    t_clear();
    t_match();
    t_mask();
    t_same();
    t_stall();
    t_readmap();
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

endmodule